// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

The controller gathers every interrupt request that targets a CPU and decides whether the CPU should take one now. Its levels run from 0 (lowest) to 16 (highest). A single non-maskable request owns level 16. A break request and a debug request sit at a fixed level 15. Each external IRQ line and each peripheral request takes a 4-bit level held in write-only priority registers.

Each clock the controller picks the highest-level pending request and compares that level with the CPU's current 4-bit mask. When the request wins, the controller raises a registered accept strobe and presents two values with it: the vector index of the winning source and the mask value the CPU should load next. These outputs stay frozen until the CPU acknowledges. Arbitration starts again one cycle after the acknowledge.

Stacking of the status word and program counter, the vector-table fetch and the CPU pipeline all sit outside this block.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A latched non-maskable request is accepted whatever the mask value, with vector 0, and loads new mask 15 (not 16).
- R2: The break request (vector 1) and the debug request (vector 2) have a fixed level of 15. They are accepted for any mask below 15 and never when the mask is 15.
- R3: Programmable levels are written on the register bus. Register address a, bits [4k+3:4k], holds the level of programmable source 4a+k. Programmable sources are numbered IRQ 0..N_IRQ-1 first, then peripherals 0..N_PER-1. All levels reset to 0.
- R4: A maskable request is accepted only when its level is strictly greater than mask_i. An equal level is refused.
- R5: On acceptance of a maskable request, new_mask_o equals the accepted level.
- R6: When several requests are pending, the highest level wins.
- R7: Among pending requests of equal level, the lowest vector wins. The vector encoding is: 0 for the non-maskable request, 1 for break, 2 for debug, 3+i for IRQ i, and 3+N_IRQ+j for peripheral j.
- R8: A source programmed to level 0 is never accepted.
- R9: The non-maskable input is detected on its rising edge and latched until its acceptance is acknowledged. Holding the input high produces a single acceptance.
- R10: accept_o, vec_o and new_mask_o stay stable until ack_i is sampled high. accept_o is then low for at least one cycle before the next acceptance.
- R11: After reset, accept_o, vec_o and new_mask_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| brk_req_i | input | 1 | Break request, level 15 |
| dbg_req_i | input | 1 | Debug-interface request, level 15 |
| irq_i | input | N_IRQ | External IRQ lines, level-sensitive |
| per_req_i | input | N_PER | Peripheral requests, level-sensitive |
| mask_i | input | 4 | Current CPU interrupt mask |
| reg_we_i | input | 1 | Priority register write strobe |
| reg_addr_i | input | RA_W | Priority register address |
| reg_wdata_i | input | 16 | Priority register write data |
| ack_i | input | 1 | CPU acknowledge of the presented acceptance |
| accept_o | output | 1 | Acceptance pending, held until acknowledged |
| vec_o | output | VEC_W | Vector index of the accepted source |
| new_mask_o | output | 4 | Mask value for the CPU to load |

## Verification
The assertions assume two things. First, ack_i is raised only while accept_o is high. Second, mask_i does not change in the cycle an acceptance is registered, so that the level-above-mask check can compare against the mask of the previous cycle. The stimulus changes inputs only on the falling edge. It raises acknowledge only in response to an observed accept strobe, and it withdraws the serviced requests in the same cycle as the acknowledge, so that a held request is never mistaken for a second acceptance.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
  localparam int LVL_W  = 4;
  localparam int ALVL_W = LVL_W + 1;
  localparam int FIELDS_PER_REG = 4;
  localparam int REG_DW = FIELDS_PER_REG * LVL_W;
  localparam int NMI_IDX = 0;
  localparam int BRK_IDX = 1;
  localparam int DBG_IDX = 2;
  localparam int N_FIXED = 3;
  localparam logic [ALVL_W-1:0] NMI_LVL = ALVL_W'(16);
  localparam logic [ALVL_W-1:0] FIX_LVL = ALVL_W'(15);
  localparam logic [LVL_W-1:0]  NMI_LOAD_MASK = LVL_W'(15);
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_acc_pkg::*;
#(
  parameter int N_PROG = 16,
  parameter int AW     = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [REG_DW-1:0]             wdata_i,
  output logic [N_PROG-1:0][LVL_W-1:0]  lvl_o
);
  for (genvar g = 0; g < N_PROG; g++) begin : g_fld
    localparam logic [AW-1:0] REG_A = AW'(g / FIELDS_PER_REG);
    localparam int            LSB   = (g % FIELDS_PER_REG) * LVL_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      lvl_o[g] <= '0;
      else if (we_i && addr_i == REG_A) lvl_o[g] <= wdata_i[LSB +: LVL_W];
    end
  end

  AST_FIELD0_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> lvl_o[0] == $past(wdata_i[LVL_W-1:0])); // R3
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic nmi_q;
  logic rise;

  assign rise = nmi_i & ~nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      if (rise)       pend_o <= 1'b1;   // new edge beats a clear
      else if (clr_i) pend_o <= 1'b0;
    end
  end

  AST_NMI_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !nmi_q) |=> pend_o); // R9
  AST_NMI_NO_RELATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && nmi_q && nmi_i) |=> !pend_o); // R9
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_acc_pkg::*;
#(
  parameter int N_SRC = 19,
  parameter int VEC_W = 5
) (
  input  logic [N_SRC-1:0]              req_i,
  input  logic [N_SRC-1:0][ALVL_W-1:0]  lvl_i,
  output logic                          win_valid_o,
  output logic [VEC_W-1:0]              win_idx_o,
  output logic [ALVL_W-1:0]             win_lvl_o
);
  // strict compare keeps the lowest index on ties; level 0 never wins
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_lvl_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && lvl_i[i] > win_lvl_o) begin
        win_valid_o = 1'b1;
        win_idx_o   = VEC_W'(i);
        win_lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_acc_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int N_PER = 8,
  localparam int N_PROG = N_IRQ + N_PER,
  localparam int N_SRC  = N_FIXED + N_PROG,
  localparam int VEC_W  = $clog2(N_SRC),
  localparam int N_REG  = (N_PROG + FIELDS_PER_REG - 1) / FIELDS_PER_REG,
  localparam int RA_W   = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic              brk_req_i,
  input  logic              dbg_req_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_PER-1:0]  per_req_i,
  input  logic [LVL_W-1:0]  mask_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  input  logic              ack_i,
  output logic              accept_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [LVL_W-1:0]  new_mask_o
);
  logic [N_PROG-1:0][LVL_W-1:0] prog_lvl;
  logic [N_SRC-1:0]             req;
  logic [N_SRC-1:0][ALVL_W-1:0] lvl;
  logic                         nmi_pend;
  logic                         nmi_clr;
  logic                         win_valid;
  logic [VEC_W-1:0]             win_idx;
  logic [ALVL_W-1:0]            win_lvl;
  logic                         take;
  logic                         ack_hit;

  irq_prio_regs #(.N_PROG(N_PROG), .AW(RA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .lvl_o  (prog_lvl)
  );

  irq_nmi_latch u_nmi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nmi_i (nmi_i),
    .clr_i (nmi_clr),
    .pend_o(nmi_pend)
  );

  always_comb begin
    req[NMI_IDX] = nmi_pend;
    req[BRK_IDX] = brk_req_i;
    req[DBG_IDX] = dbg_req_i;
    lvl[NMI_IDX] = NMI_LVL;
    lvl[BRK_IDX] = FIX_LVL;
    lvl[DBG_IDX] = FIX_LVL;
  end

  for (genvar g = 0; g < N_PROG; g++) begin : g_src
    if (g < N_IRQ) begin : g_irq
      assign req[N_FIXED+g] = irq_i[g];
    end else begin : g_per
      assign req[N_FIXED+g] = per_req_i[g-N_IRQ];
    end
    assign lvl[N_FIXED+g] = {1'b0, prog_lvl[g]};
  end

  irq_arbiter #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .req_i      (req),
    .lvl_i      (lvl),
    .win_valid_o(win_valid),
    .win_idx_o  (win_idx),
    .win_lvl_o  (win_lvl)
  );

  assign take    = !accept_o && win_valid && (win_lvl > {1'b0, mask_i});
  assign ack_hit = accept_o && ack_i;
  assign nmi_clr = ack_hit && (vec_o == VEC_W'(NMI_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o   <= 1'b0;
      vec_o      <= '0;
      new_mask_o <= '0;
    end else if (ack_hit) begin
      accept_o <= 1'b0;
    end else if (take) begin
      accept_o   <= 1'b1;
      vec_o      <= win_idx;
      new_mask_o <= win_lvl[ALVL_W-1] ? NMI_LOAD_MASK : win_lvl[LVL_W-1:0];
    end
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !ack_i) |=> (accept_o && $stable(vec_o) && $stable(new_mask_o))); // R10
  AST_GAP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && ack_i) |=> !accept_o); // R10
  AST_NMI_LOADS_15: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(accept_o) && vec_o == '0) |-> new_mask_o == LVL_W'(15)); // R1
  AST_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(accept_o) && vec_o != '0) |-> new_mask_o > $past(mask_i)); // R4
  AST_NO_LEVEL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_o) |-> new_mask_o != '0); // R8
  AST_FIXED_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(accept_o) && (vec_o == VEC_W'(BRK_IDX) || vec_o == VEC_W'(DBG_IDX)))
      |-> new_mask_o == LVL_W'(15)); // R2
endmodule

// File: tb/sim_irq_accept_ctrl.sv
module sim_irq_accept_ctrl;
  localparam int N_IRQ = 8;
  localparam int N_PER = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       nmi_i = 1'b0, brk_req_i = 1'b0, dbg_req_i = 1'b0, ack_i = 1'b0;
  logic [7:0] irq_i = '0, per_req_i = '0;
  logic [3:0] mask_i = '0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic       accept_o;
  logic [4:0] vec_o;
  logic [3:0] new_mask_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_accept_ctrl #(.N_IRQ(N_IRQ), .N_PER(N_PER)) u0 (
    .clk_i, .rst_ni, .nmi_i, .brk_req_i, .dbg_req_i, .irq_i, .per_req_i,
    .mask_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .ack_i,
    .accept_o, .vec_o, .new_mask_o
  );

  typedef struct packed {
    logic [3:0] mask;
    logic [7:0] irq;
    logic [7:0] per;
    logic       brk;
    logic       dbg;
    logic       acc;
    logic [4:0] vec;
    logic [3:0] nm;
  } row_t;

  // levels: irq 3,7,7,0,15,1,9,12  per 7,5,15,2,10,0,4,8
  localparam int NROW = 14;
  localparam row_t TBL [NROW] = '{
    '{4'd0,  8'h01, 8'h00, 1'b0, 1'b0, 1'b1, 5'd3,  4'd3 },
    '{4'd3,  8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 5'd0,  4'd0 },
    '{4'd2,  8'h01, 8'h00, 1'b0, 1'b0, 1'b1, 5'd3,  4'd3 },
    '{4'd0,  8'h06, 8'h00, 1'b0, 1'b0, 1'b1, 5'd4,  4'd7 },
    '{4'd0,  8'h04, 8'h01, 1'b0, 1'b0, 1'b1, 5'd5,  4'd7 },
    '{4'd0,  8'h08, 8'h00, 1'b0, 1'b0, 1'b0, 5'd0,  4'd0 },
    '{4'd0,  8'h41, 8'h10, 1'b0, 1'b0, 1'b1, 5'd15, 4'd10},
    '{4'd14, 8'h10, 8'h00, 1'b0, 1'b0, 1'b1, 5'd7,  4'd15},
    '{4'd0,  8'h10, 8'h00, 1'b1, 1'b0, 1'b1, 5'd1,  4'd15},
    '{4'd14, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 5'd2,  4'd15},
    '{4'd15, 8'h10, 8'h00, 1'b1, 1'b1, 1'b0, 5'd0,  4'd0 },
    '{4'd0,  8'h00, 8'h04, 1'b0, 1'b1, 1'b1, 5'd2,  4'd15},
    '{4'd9,  8'h40, 8'h80, 1'b0, 1'b0, 1'b0, 5'd0,  4'd0 },
    '{4'd0,  8'h20, 8'h20, 1'b0, 1'b0, 1'b1, 5'd8,  4'd1 }
  };

  function automatic string row_tag(input int r);
    case (r)
      0:  return "R3 R5";
      1:  return "R4 equal";
      2:  return "R4 above";
      3:  return "R7 irq tie";
      4:  return "R7 irq/per tie";
      5:  return "R8 level0";
      6:  return "R6 highest";
      7:  return "R5 level15";
      8:  return "R2 R7 break tie";
      9:  return "R2 debug";
      10: return "R2 R4 mask15";
      11: return "R2 R7 debug tie";
      12: return "R4 below";
      default: return "R8 R6 level1";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic clear_reqs();
    irq_i = '0; per_req_i = '0; brk_req_i = 1'b0; dbg_req_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R11 accept", int'(accept_o), 0);
    chk("R11 vec", int'(vec_o), 0);
    chk("R11 mask", int'(new_mask_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // reset levels are 0: nothing accepted
    @(negedge clk_i) irq_i = 8'hFF; per_req_i = 8'hFF; mask_i = 4'd0;
    @(posedge clk_i); #1;
    chk("R3 reset level", int'(accept_o), 0);
    @(negedge clk_i) clear_reqs();

    wr(2'd0, 16'h0773);
    wr(2'd1, 16'hC91F);
    wr(2'd2, 16'h2F57);
    wr(2'd3, 16'h840A);

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk_i);
      mask_i = TBL[r].mask; irq_i = TBL[r].irq; per_req_i = TBL[r].per;
      brk_req_i = TBL[r].brk; dbg_req_i = TBL[r].dbg;
      @(posedge clk_i); #1;
      chk({row_tag(r), " accept"}, int'(accept_o), int'(TBL[r].acc));
      if (TBL[r].acc) begin
        chk({row_tag(r), " vec"}, int'(vec_o), int'(TBL[r].vec));
        chk({row_tag(r), " mask"}, int'(new_mask_o), int'(TBL[r].nm));
      end
      @(negedge clk_i);
      ack_i = accept_o;
      clear_reqs();
      @(posedge clk_i); #1;
      chk("R10 low after ack", int'(accept_o), 0);
      @(negedge clk_i) ack_i = 1'b0;
    end

    // NMI accepted under mask 15, held, single acceptance
    @(negedge clk_i) mask_i = 4'd15; nmi_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R9 latch cycle", int'(accept_o), 0);
    @(posedge clk_i); #1;
    chk("R1 accept", int'(accept_o), 1);
    chk("R1 vec", int'(vec_o), 0);
    chk("R1 mask", int'(new_mask_o), 15);
    @(negedge clk_i) mask_i = 4'd0; brk_req_i = 1'b1; irq_i = 8'h10;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10 hold accept", int'(accept_o), 1);
    chk("R10 hold vec", int'(vec_o), 0);
    chk("R10 hold mask", int'(new_mask_o), 15);
    @(negedge clk_i) ack_i = 1'b1; clear_reqs();
    @(posedge clk_i); #1;
    chk("R10 ack drop", int'(accept_o), 0);
    @(negedge clk_i) ack_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 held high once", int'(accept_o), 0);
    @(negedge clk_i) nmi_i = 1'b0;

    // NMI beats break
    @(negedge clk_i) mask_i = 4'd15; nmi_i = 1'b1; brk_req_i = 1'b1;
    @(negedge clk_i) mask_i = 4'd0;
    @(posedge clk_i); #1;
    chk("R6 nmi over break", int'(vec_o), 0);
    chk("R6 nmi accept", int'(accept_o), 1);
    @(negedge clk_i) ack_i = 1'b1; brk_req_i = 1'b0; nmi_i = 1'b0;
    @(negedge clk_i) ack_i = 1'b0;

    // reprogram irq0 to 12
    wr(2'd0, 16'h077C);
    @(negedge clk_i) mask_i = 4'd11; irq_i = 8'h01;
    @(posedge clk_i); #1;
    chk("R3 reprogram accept", int'(accept_o), 1);
    chk("R3 reprogram mask", int'(new_mask_o), 12);
    @(negedge clk_i) ack_i = 1'b1; clear_reqs();
    @(negedge clk_i) ack_i = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule